// File: doc/BRIEF.md
# Receive FIFO Flow-Control Hysteresis Controller

This block decides when a UART receiver must ask the far-end sender to pause and when it may let it continue. It watches the fill level of the receive FIFO. It compares that level against two programmable thresholds that form a hysteresis band. When the level climbs to the upper threshold the controller enters a halted state. It stays halted until the level drains down to the lower threshold, and then it returns to the running state.

The halt decision can be signalled in two ways. In hardware signalling it appears on an active-low modem-control line, which is high while halted. In software signalling the controller pulses a request to the transmitter, which then emits one XOFF or one XON character. A line-select input chooses which of two modem-control outputs carries the hardware signal. The other line then simply carries its manually programmed value. The FIFO itself and the character transmitter live outside this block.

Top module: `fc_rx_hysteresis`

## Requirements
- R1: While `rst` is high, `rts_n` and `dtr_n` are both 0, `send_xoff` and `send_xon` are both 0, and the controller is in the running state.
- R2: Each 8-bit threshold register decodes to an effective level as follows: 0x00 and 0x01 both give 1, values from 0x02 to 0x80 give their own value, and values above 0x80 give 128.
- R3: When running, a FIFO level greater than or equal to the effective high threshold moves the controller to halted. In hardware mode the selected flow line reads 1 after the next rising clock edge.
- R4: When halted, a FIFO level less than or equal to the effective low threshold moves the controller to running. In hardware mode the selected flow line reads 0 after the next rising clock edge.
- R5: Hysteresis: while running, a level below the high threshold keeps the controller running, and while halted, a level above the low threshold keeps it halted.
- R6: With `sw_mode`=1, every running-to-halted change gives exactly one single-cycle `send_xoff` pulse, and every halted-to-running change gives exactly one single-cycle `send_xon` pulse. Both pulses appear in the same cycle as the state change. No pulse repeats while the state holds, the two pulses are never high together, and with `sw_mode`=0 neither pulse occurs.
- R7: With `sw_mode`=1, the selected flow line is held at 0 (ready) whatever the state.
- R8: With `map_dtr`=0 the flow signal drives `rts_n` and `dtr_n` follows `man_dtr_n`. With `map_dtr`=1 the flow signal drives `dtr_n` and `rts_n` follows `man_rts_n`. In both cases the value is registered and appears one clock later.
- R9: Every output is registered. Each output reflects the inputs sampled at the preceding rising clock edge, with no combinational path from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | LVL_W (8) | Current receive FIFO fill level |
| hi_thr_reg | input | THR_W (8) | High threshold register value |
| lo_thr_reg | input | THR_W (8) | Low threshold register value |
| sw_mode | input | 1 | 1 = software (XON/XOFF) signalling, 0 = hardware line |
| map_dtr | input | 1 | 1 = flow signal on `dtr_n`, 0 = flow signal on `rts_n` |
| man_rts_n | input | 1 | Manual value for `rts_n` when it does not carry flow control |
| man_dtr_n | input | 1 | Manual value for `dtr_n` when it does not carry flow control |
| rts_n | output | 1 | Active-low request-to-send line |
| dtr_n | output | 1 | Active-low data-terminal-ready line |
| send_xoff | output | 1 | Single-cycle request to transmit one XOFF |
| send_xon | output | 1 | Single-cycle request to transmit one XON |

## Verification
The bench first walks the FIFO level slowly up through the high threshold and back down through the low threshold. Comparing levels just inside the band with levels on each edge shows apart an inclusive comparison, an exclusive one, and a band that has collapsed. It then sets thresholds to 0x00, 0x01, 0x80 and values above 0x80, which tells correct decoding apart from a decoder that takes the raw value or wraps. Held levels in software mode show a repeated pulse apart from a single one, and toggling the manual line inputs under each mapping shows which line carries the flow signal. A long random walk of levels, thresholds, modes and mappings is then compared every cycle against a behavioural model.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {
    FC_RUN  = 1'b0,
    FC_HALT = 1'b1
  } fc_state_e;
endpackage

// File: rtl/fc_thr_decode.sv
module fc_thr_decode #(
  parameter int THR_W   = 8,
  parameter int LVL_W   = 8,
  parameter int MAX_LVL = 128
) (
  input  logic [THR_W-1:0] raw,
  output logic [LVL_W-1:0] eff
);
  localparam logic [THR_W-1:0] MAX_T = THR_W'(MAX_LVL);
  localparam logic [THR_W-1:0] ONE_T = THR_W'(1);

  always_comb begin
    if (raw <= ONE_T)      eff = LVL_W'(1);
    else if (raw > MAX_T)  eff = LVL_W'(MAX_LVL);
    else                   eff = LVL_W'(raw);
  end
endmodule

// File: rtl/fc_hyst_fsm.sv
module fc_hyst_fsm
  import fc_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi_eff,
  input  logic [LVL_W-1:0] lo_eff,
  input  logic             sw_mode,
  output logic             halt_nxt,
  output logic             halt_q,
  output logic             xoff_q,
  output logic             xon_q
);
  fc_state_e state_q, state_d;
  logic      go_halt, go_run;

  always_comb begin
    go_halt = (state_q == FC_RUN)  && (level >= hi_eff);
    go_run  = (state_q == FC_HALT) && (level <= lo_eff);
    state_d = state_q;
    if (go_halt)     state_d = FC_HALT;
    else if (go_run) state_d = FC_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FC_RUN;
      xoff_q  <= 1'b0;
      xon_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      xoff_q  <= go_halt && sw_mode;
      xon_q   <= go_run && sw_mode;
    end
  end

  assign halt_nxt = (state_d == FC_HALT);
  assign halt_q   = (state_q == FC_HALT);
endmodule

// File: rtl/fc_line_map.sv
module fc_line_map (
  input  logic clk,
  input  logic rst,
  input  logic halt_nxt,
  input  logic sw_mode,
  input  logic map_dtr,
  input  logic man_rts_n,
  input  logic man_dtr_n,
  output logic rts_n,
  output logic dtr_n
);
  logic flow_n;

  // Software signalling keeps the flow line in the ready (low) state.
  assign flow_n = sw_mode ? 1'b0 : halt_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b0;
      dtr_n <= 1'b0;
    end else begin
      rts_n <= map_dtr ? man_rts_n : flow_n;
      dtr_n <= map_dtr ? flow_n    : man_dtr_n;
    end
  end
endmodule

// File: rtl/fc_rx_hysteresis.sv
module fc_rx_hysteresis #(
  parameter int THR_W   = 8,
  parameter int LVL_W   = 8,
  parameter int MAX_LVL = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [THR_W-1:0] hi_thr_reg,
  input  logic [THR_W-1:0] lo_thr_reg,
  input  logic             sw_mode,
  input  logic             map_dtr,
  input  logic             man_rts_n,
  input  logic             man_dtr_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             send_xoff,
  output logic             send_xon
);
  localparam int N_THR = 2;

  logic [THR_W-1:0] thr_raw [N_THR];
  logic [LVL_W-1:0] thr_eff [N_THR];
  logic             halt_nxt, halt_q;

  assign thr_raw[0] = hi_thr_reg;
  assign thr_raw[1] = lo_thr_reg;

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    fc_thr_decode #(
      .THR_W(THR_W), .LVL_W(LVL_W), .MAX_LVL(MAX_LVL)
    ) u_dec (
      .raw(thr_raw[g]),
      .eff(thr_eff[g])
    );
  end

  fc_hyst_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk(clk), .rst(rst),
    .level(fifo_level),
    .hi_eff(thr_eff[0]), .lo_eff(thr_eff[1]),
    .sw_mode(sw_mode),
    .halt_nxt(halt_nxt), .halt_q(halt_q),
    .xoff_q(send_xoff), .xon_q(send_xon)
  );

  fc_line_map u_map (
    .clk(clk), .rst(rst),
    .halt_nxt(halt_nxt), .sw_mode(sw_mode), .map_dtr(map_dtr),
    .man_rts_n(man_rts_n), .man_dtr_n(man_dtr_n),
    .rts_n(rts_n), .dtr_n(dtr_n)
  );
endmodule

// File: rtl/fc_rx_hysteresis_chk.sv
module fc_rx_hysteresis_chk #(
  parameter int THR_W   = 8,
  parameter int LVL_W   = 8,
  parameter int MAX_LVL = 128
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] fifo_level,
  input logic [THR_W-1:0] hi_thr_reg,
  input logic [THR_W-1:0] lo_thr_reg,
  input logic             sw_mode,
  input logic             map_dtr,
  input logic             man_rts_n,
  input logic             man_dtr_n,
  input logic             rts_n,
  input logic             dtr_n,
  input logic             send_xoff,
  input logic             send_xon,
  input logic             halted
);
  function automatic int thr_level(input logic [THR_W-1:0] v);
    int x;
    x = int'(v);
    if (x < 1) x = 1;
    if (x > MAX_LVL) x = MAX_LVL;
    return x;
  endfunction

  int hi_e, lo_e, lvl;
  always_comb begin
    hi_e = thr_level(hi_thr_reg);
    lo_e = thr_level(lo_thr_reg);
    lvl  = int'(fifo_level);
  end

  // R1: outputs quiet during reset
  always @(posedge clk) if (rst) begin
    a_r1_reset_quiet: assert (!send_xoff && !send_xon)
      else $error("R1 pulse during reset");
  end

  a_r6_not_both: assert property (@(posedge clk) disable iff (rst)
    !(send_xoff && send_xon));

  a_r3_halt_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(lvl) >= $past(hi_e));

  a_r4_run_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> $past(lvl) <= $past(lo_e));

  a_r5_hold_run: assert property (@(posedge clk) disable iff (rst)
    (!halted && lvl < hi_e) |=> !halted);

  a_r5_hold_halt: assert property (@(posedge clk) disable iff (rst)
    (halted && lvl > lo_e) |=> halted);

  a_r6_xoff_edge: assert property (@(posedge clk) disable iff (rst)
    (!halted && lvl >= hi_e && sw_mode) |=> send_xoff);

  a_r6_no_repeat: assert property (@(posedge clk) disable iff (rst)
    send_xoff |=> !send_xoff);

  a_r7_sw_ready: assert property (@(posedge clk) disable iff (rst)
    (sw_mode && !map_dtr) |=> !rts_n);

  a_r8_dtr_pass: assert property (@(posedge clk) disable iff (rst)
    !map_dtr |=> dtr_n == $past(man_dtr_n));

  a_r8_rts_pass: assert property (@(posedge clk) disable iff (rst)
    map_dtr |=> rts_n == $past(man_rts_n));

  a_r3_hw_line: assert property (@(posedge clk) disable iff (rst)
    (!sw_mode && map_dtr) |=> dtr_n == halted);
endmodule

bind fc_rx_hysteresis fc_rx_hysteresis_chk #(
  .THR_W(THR_W), .LVL_W(LVL_W), .MAX_LVL(MAX_LVL)
) u_chk (
  .clk(clk), .rst(rst), .fifo_level(fifo_level),
  .hi_thr_reg(hi_thr_reg), .lo_thr_reg(lo_thr_reg),
  .sw_mode(sw_mode), .map_dtr(map_dtr),
  .man_rts_n(man_rts_n), .man_dtr_n(man_dtr_n),
  .rts_n(rts_n), .dtr_n(dtr_n),
  .send_xoff(send_xoff), .send_xon(send_xon),
  .halted(halt_q)
);

// File: tb/tb_fc_rx_hysteresis.sv
`timescale 1ns/1ps
module tb_fc_rx_hysteresis;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] fifo_level = '0;
  logic [7:0] hi_thr_reg = 8'd16;
  logic [7:0] lo_thr_reg = 8'd4;
  logic       sw_mode = 1'b0, map_dtr = 1'b0;
  logic       man_rts_n = 1'b1, man_dtr_n = 1'b1;
  logic       rts_n, dtr_n, send_xoff, send_xon;

  int tests = 0, fails = 0;
  bit model_on = 0, done = 0;

  always #5 clk = ~clk;

  fc_rx_hysteresis dut (.*);

  // Behavioural reference model
  int m_halt, m_rts, m_dtr, m_xoff, m_xon;

  function automatic int eff_of(input int v);
    if (v <= 1) return 1;
    if (v > 128) return 128;
    return v;
  endfunction

  always @(posedge clk) begin
    int flow;
    if (rst) begin
      m_halt = 0; m_rts = 0; m_dtr = 0; m_xoff = 0; m_xon = 0;
    end else begin
      m_xoff = 0; m_xon = 0;
      if (m_halt == 0 && int'(fifo_level) >= eff_of(int'(hi_thr_reg))) begin
        m_halt = 1; m_xoff = int'(sw_mode);
      end else if (m_halt == 1 && int'(fifo_level) <= eff_of(int'(lo_thr_reg))) begin
        m_halt = 0; m_xon = int'(sw_mode);
      end
      flow = sw_mode ? 0 : m_halt;
      if (map_dtr) begin m_dtr = flow; m_rts = int'(man_rts_n); end
      else         begin m_rts = flow; m_dtr = int'(man_dtr_n); end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: every-cycle comparison against the model
  always @(negedge clk) if (model_on) begin
    chk("R9 model rts_n", int'(rts_n), m_rts);
    chk("R9 model dtr_n", int'(dtr_n), m_dtr);
    chk("R9 model send_xoff", int'(send_xoff), m_xoff);
    chk("R9 model send_xon", int'(send_xon), m_xon);
  end

  task automatic lvl(input int v);
    fifo_level = 8'(v);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rts_n in reset", int'(rts_n), 0);
    chk("R1 dtr_n in reset", int'(dtr_n), 0);
    chk("R1 xoff in reset", int'(send_xoff), 0);
    chk("R1 xon in reset", int'(send_xon), 0);
    rst = 1'b0;
    model_on = 1;
    @(negedge clk);

    // Hardware mode on rts_n, band 4..16
    lvl(15); chk("R5 below high", int'(rts_n), 0);
    chk("R8 dtr follows manual", int'(dtr_n), 1);
    lvl(16); chk("R3 halt at high", int'(rts_n), 1);
    chk("R6 no xoff in hw mode", int'(send_xoff), 0);
    lvl(10); chk("R5 hold in band", int'(rts_n), 1);
    lvl(5);  chk("R5 above low", int'(rts_n), 1);
    lvl(4);  chk("R4 resume at low", int'(rts_n), 0);
    chk("R6 no xon in hw mode", int'(send_xon), 0);

    // Threshold decoding
    hi_thr_reg = 8'h00; lvl(0);
    lvl(1); chk("R2 0x00 means 1", int'(rts_n), 1);
    lo_thr_reg = 8'h00; lvl(1); chk("R2 low 0x00 means 1", int'(rts_n), 0);
    hi_thr_reg = 8'h01; lvl(0); chk("R2 0x01 level 0 runs", int'(rts_n), 0);
    lvl(1); chk("R2 0x01 means 1", int'(rts_n), 1);
    lo_thr_reg = 8'd4; lvl(0);
    hi_thr_reg = 8'hFF; lvl(127); chk("R2 clamp not yet", int'(rts_n), 0);
    lvl(128); chk("R2 clamp to 128", int'(rts_n), 1);
    lvl(0);
    hi_thr_reg = 8'h80; lvl(127); chk("R2 0x80 not yet", int'(rts_n), 0);
    lvl(128); chk("R2 0x80 is 128", int'(rts_n), 1);
    lvl(0);

    // Software mode
    hi_thr_reg = 8'd16; sw_mode = 1'b1;
    lvl(20); chk("R6 xoff pulse", int'(send_xoff), 1);
    chk("R7 line ready in sw", int'(rts_n), 0);
    lvl(20); chk("R6 xoff not repeated", int'(send_xoff), 0);
    lvl(8);  chk("R6 no xon in band", int'(send_xon), 0);
    lvl(3);  chk("R6 xon pulse", int'(send_xon), 1);
    chk("R6 not both", int'(send_xoff), 0);
    lvl(3);  chk("R6 xon not repeated", int'(send_xon), 0);

    // Mapping to dtr_n
    sw_mode = 1'b0; map_dtr = 1'b1; man_rts_n = 1'b0;
    lvl(2); chk("R8 rts follows manual 0", int'(rts_n), 0);
    man_rts_n = 1'b1;
    lvl(2); chk("R8 rts follows manual 1", int'(rts_n), 1);
    lvl(30); chk("R8 flow on dtr_n", int'(dtr_n), 1);
    chk("R8 rts unaffected", int'(rts_n), 1);
    lvl(1); chk("R8 dtr_n resumes", int'(dtr_n), 0);

    // Random walk against the model
    for (int i = 0; i < 4000; i++) begin
      int v;
      v = int'(fifo_level) + int'($urandom_range(0, 8)) - 4;
      if (v < 0) v = 0;
      if (v > 140) v = 140;
      fifo_level = 8'(v);
      if ($urandom_range(0, 199) == 0) hi_thr_reg = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 199) == 0) lo_thr_reg = 8'($urandom_range(0, 130));
      if ($urandom_range(0, 299) == 0) sw_mode = ~sw_mode;
      if ($urandom_range(0, 299) == 0) map_dtr = ~map_dtr;
      if ($urandom_range(0, 15) == 0) man_rts_n = ~man_rts_n;
      if ($urandom_range(0, 15) == 0) man_dtr_n = ~man_dtr_n;
      @(negedge clk);
    end
    finish_run();
  end
endmodule